// File: doc/BRIEF.md
# Rounding dual multiply-accumulate-high unit

This block is a vector reduction datapath. It takes two vector operands of four 32-bit lanes each and a 64-bit running sum given as two 32-bit halves. It multiplies the lanes in pairs and folds every product into a widened internal sum. The internal sum carries eight extra fraction bits below the running sum. After each active lane a rounding increment of half a unit is added to it. Only the upper 64 bits of the internal sum are returned, again as two 32-bit halves.

Mode inputs select several options. The lane products can be signed or unsigned. The odd lanes can subtract their product instead of adding it. Exchange mode pairs each lane of the N operand with the neighbouring lane of the M operand. A byte-granular predicate mask disables individual lanes.

An operation is launched with a one-cycle `start` while the unit is idle. The unit then works through one lane per clock, lowest lane first. It raises `done` for one cycle with the result. Two requests are rejected at launch: unsigned with subtract, and unsigned with exchange. For these the unit raises `done` together with an illegal flag and returns the input sum untouched.

Top module: `rdmah_unit`

## Requirements
- R1: After reset, `done`, `illegal` and `busy` are low and `res_hi`/`res_lo` read zero.
- R2: The input sum {acc_hi_in, acc_lo_in} is placed at bits 71:8 of a 72-bit internal sum, with bits 7:0 cleared. The result is bits 71:8 of the final internal sum: `res_hi` carries result bits 63:32 and `res_lo` carries bits 31:0.
- R3: After each active lane's product has been applied, 128 is added to the internal sum. All arithmetic wraps modulo 2^72.
- R4: With `unsigned_mode`=0, each lane product is the signed 64-bit product of two two's-complement 32-bit lanes, sign-extended to 72 bits.
- R5: With `unsigned_mode`=1, each lane product is the unsigned 64-bit product, zero-extended to 72 bits.
- R6: Even lanes (0, 2) always add their product. With `sub_odd`=1, odd lanes (1, 3) subtract their product; otherwise they add it.
- R7: Lane e occupies bits 32e+31:32e of each vector. Without `exchange`, lane e multiplies N lane e by M lane e. With `exchange`=1, even lane e uses N lane e+1 and odd lane e uses N lane e-1, in both cases times M lane e.
- R8: Lane e is active only when `pred_mask` bit 4e is 1. The other mask bits are ignored. An inactive lane adds neither a product nor the rounding increment.
- R9: A start with `unsigned_mode`=1 and either `sub_odd` or `exchange` set raises `done` and `illegal` together for exactly one cycle on the next clock. The result is {acc_hi_in, acc_lo_in} unchanged.
- R10: A legal start raises `busy` on the next clock. Lanes 0 to 3 are handled on the following four clocks, and `done` is high for one cycle after the fourth. `start` is ignored while `busy` is high.
- R11: `res_hi`/`res_lo` change only in a cycle where `done` is high, and hold their value between completions.
- R12: A start presented in the cycle where `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, honoured when not busy |
| vec_n | input | 128 | First operand, four 32-bit lanes |
| vec_m | input | 128 | Second operand, four 32-bit lanes |
| acc_hi_in | input | 32 | Upper half of input sum |
| acc_lo_in | input | 32 | Lower half of input sum |
| pred_mask | input | 16 | Byte predicate, bit 4e enables lane e |
| unsigned_mode | input | 1 | 1 selects unsigned products |
| sub_odd | input | 1 | 1 makes odd lanes subtract |
| exchange | input | 1 | 1 pairs N lanes crosswise |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejected-mode flag, with done |
| res_hi | output | 32 | Upper half of result |
| res_lo | output | 32 | Lower half of result |

## Verification
Two events can meet in one cycle: the completion of one operation and the launch of the next. The bench provokes this by raising `start` at the moment it sees `done`, using both a legal follow-up and a rejected follow-up. It judges the overlap by comparing, every clock, the busy/done/illegal pattern and both result halves against a behavioural model. The model must show the earlier result held for exactly that one cycle and the new result after it. A start raised in the middle of an operation is also injected, and the original result must come through unaffected.

// File: rtl/rdmah_pkg.sv
package rdmah_pkg;
   typedef struct packed {
      logic uns;
      logic sub;
      logic xchg;
   } mode_t;

   function automatic logic mode_rejected(mode_t m);
      return m.uns & (m.sub | m.xchg);
   endfunction
endpackage

// File: rtl/rdmah_lane_pick.sv
module rdmah_lane_pick #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int VEC_W = LANE_W * LANES,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic [VEC_W-1:0]  vec_n,
   input  logic [VEC_W-1:0]  vec_m,
   input  logic [IDX_W-1:0]  idx,
   input  logic              xchg,
   output logic [LANE_W-1:0] op_n,
   output logic [LANE_W-1:0] op_m
);
   logic [LANE_W-1:0] n_arr [LANES];
   logic [LANE_W-1:0] m_arr [LANES];
   logic [IDX_W-1:0]  n_idx;

   for (genvar g = 0; g < LANES; g++) begin : g_split
      assign n_arr[g] = vec_n[g*LANE_W +: LANE_W];
      assign m_arr[g] = vec_m[g*LANE_W +: LANE_W];
   end

   always_comb begin
      n_idx = xchg ? (idx ^ IDX_W'(1)) : idx;
      op_n  = n_arr[n_idx];
      op_m  = m_arr[idx];
   end
endmodule

// File: rtl/rdmah_mul.sv
module rdmah_mul #(
   parameter int LANE_W = 32,
   localparam int PROD_W = 2 * LANE_W
) (
   input  logic              uns,
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   output logic [PROD_W-1:0] prod
);
   logic signed [LANE_W:0]   a_x, b_x;
   logic signed [PROD_W+1:0] full;
   logic                     unused_prod_top;

   always_comb begin
      a_x  = {(~uns) & a[LANE_W-1], a};
      b_x  = {(~uns) & b[LANE_W-1], b};
      full = a_x * b_x;
      prod = full[PROD_W-1:0];
   end

   assign unused_prod_top = ^full[PROD_W+1:PROD_W];
endmodule

// File: rtl/rdmah_acc_step.sv
module rdmah_acc_step #(
   parameter int WIDE_W = 72,
   parameter int PROD_W = 64,
   parameter int GUARD  = 8
) (
   input  logic              uns,
   input  logic              subtract,
   input  logic              active,
   input  logic [WIDE_W-1:0] acc,
   input  logic [PROD_W-1:0] prod,
   output logic [WIDE_W-1:0] acc_next
);
   localparam logic [WIDE_W-1:0] RND = WIDE_W'(1) << (GUARD - 1);
   logic [WIDE_W-1:0] p_ext, sum;

   always_comb begin
      p_ext    = uns ? {{(WIDE_W-PROD_W){1'b0}}, prod}
                     : {{(WIDE_W-PROD_W){prod[PROD_W-1]}}, prod};
      sum      = subtract ? (acc - p_ext) : (acc + p_ext);
      acc_next = active ? (sum + RND) : acc;
   end
endmodule

// File: rtl/rdmah_unit.sv
module rdmah_unit #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   parameter int ACC_W  = 64,
   parameter int GUARD  = 8,
   localparam int VEC_W  = LANE_W * LANES,
   localparam int MASK_W = VEC_W / 8,
   localparam int HALF_W = ACC_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VEC_W-1:0]  vec_n,
   input  logic [VEC_W-1:0]  vec_m,
   input  logic [HALF_W-1:0] acc_hi_in,
   input  logic [HALF_W-1:0] acc_lo_in,
   input  logic [MASK_W-1:0] pred_mask,
   input  logic              unsigned_mode,
   input  logic              sub_odd,
   input  logic              exchange,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic [HALF_W-1:0] res_hi,
   output logic [HALF_W-1:0] res_lo
);
   import rdmah_pkg::*;

   localparam int WIDE_W = ACC_W + GUARD;
   localparam int PROD_W = 2 * LANE_W;
   localparam int IDX_W  = $clog2(LANES);
   localparam int LANE_B = LANE_W / 8;

   if (LANES < 2 || LANES % 2 != 0) begin : g_chk_lanes
      $error("rdmah_unit: LANES must be even and at least 2");
   end
   if (LANE_W % 8 != 0) begin : g_chk_lane_w
      $error("rdmah_unit: LANE_W must be a whole number of bytes");
   end
   if (GUARD < 1 || PROD_W > WIDE_W) begin : g_chk_guard
      $error("rdmah_unit: GUARD too small for product width");
   end
   if (ACC_W % 2 != 0) begin : g_chk_acc
      $error("rdmah_unit: ACC_W must be even");
   end

   logic              busy_q, done_q, ill_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WIDE_W-1:0] acc_q, acc_nxt;
   logic [VEC_W-1:0]  n_q, m_q;
   logic [LANES-1:0]  act_q, act_in;
   mode_t             mode_q, mode_in;
   logic [ACC_W-1:0]  res_q;
   logic [LANE_W-1:0] op_n, op_m;
   logic [PROD_W-1:0] prod;
   logic              lane_on, last_lane;
   logic              unused_mask;

   for (genvar g = 0; g < LANES; g++) begin : g_act
      assign act_in[g] = pred_mask[g*LANE_B];
   end
   assign unused_mask = ^pred_mask;

   assign mode_in   = '{uns: unsigned_mode, sub: sub_odd, xchg: exchange};
   assign lane_on   = act_q[idx_q];
   assign last_lane = (idx_q == IDX_W'(LANES - 1));

   rdmah_lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
      .vec_n(n_q), .vec_m(m_q), .idx(idx_q), .xchg(mode_q.xchg),
      .op_n(op_n), .op_m(op_m)
   );

   rdmah_mul #(.LANE_W(LANE_W)) u_mul (
      .uns(mode_q.uns), .a(op_n), .b(op_m), .prod(prod)
   );

   rdmah_acc_step #(.WIDE_W(WIDE_W), .PROD_W(PROD_W), .GUARD(GUARD)) u_step (
      .uns(mode_q.uns), .subtract(mode_q.sub & idx_q[0]), .active(lane_on),
      .acc(acc_q), .prod(prod), .acc_next(acc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         idx_q  <= '0;
         acc_q  <= '0;
         n_q    <= '0;
         m_q    <= '0;
         act_q  <= '0;
         mode_q <= '0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         if (busy_q) begin
            acc_q <= acc_nxt;
            if (last_lane) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= acc_nxt[WIDE_W-1:GUARD];
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end else if (start) begin
            if (mode_rejected(mode_in)) begin
               done_q <= 1'b1;
               ill_q  <= 1'b1;
               res_q  <= {acc_hi_in, acc_lo_in};
            end else begin
               busy_q <= 1'b1;
               idx_q  <= '0;
               acc_q  <= {acc_hi_in, acc_lo_in, GUARD'(0)};
               n_q    <= vec_n;
               m_q    <= vec_m;
               act_q  <= act_in;
               mode_q <= mode_in;
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign illegal = ill_q;
   assign res_hi  = res_q[ACC_W-1:HALF_W];
   assign res_lo  = res_q[HALF_W-1:0];

   AST_LANE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last_lane |=> idx_q == IDX_W'($past(idx_q) + 1'b1)); // R10
   AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !done_q); // R10
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && last_lane |=> done_q && !busy_q); // R10
   AST_IDLE_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !lane_on |=> acc_q == $past(acc_q)); // R8
   AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ill_q |-> done_q); // R9
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(res_q)); // R11
endmodule

// File: tb/rdmah_unit_test.sv
module rdmah_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] vec_n = '0, vec_m = '0;
   logic [31:0]  acc_hi_in = '0, acc_lo_in = '0;
   logic [15:0]  pred_mask = '0;
   logic         unsigned_mode = 1'b0, sub_odd = 1'b0, exchange = 1'b0;
   logic         busy, done, illegal;
   logic [31:0]  res_hi, res_lo;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   rdmah_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_n(vec_n), .vec_m(vec_m),
      .acc_hi_in(acc_hi_in), .acc_lo_in(acc_lo_in), .pred_mask(pred_mask),
      .unsigned_mode(unsigned_mode), .sub_odd(sub_odd), .exchange(exchange),
      .busy(busy), .done(done), .illegal(illegal), .res_hi(res_hi), .res_lo(res_lo)
   );

   // behavioural reference: 80-bit integer sum, lane by lane
   function automatic logic [63:0] ref_calc(logic [127:0] n, logic [127:0] m,
         logic [63:0] a, logic [15:0] msk, bit u, bit s, bit x);
      logic [79:0] acc;
      logic [79:0] p;
      acc = {{16{a[63]}}, a} << 8;
      for (int e = 0; e < 4; e++) begin
         if (msk[4*e]) begin
            int nl;
            logic [31:0] na, mb;
            nl = !x ? e : ((e % 2 == 0) ? e + 1 : e - 1);
            na = n[nl*32 +: 32];
            mb = m[e*32 +: 32];
            if (u) begin
               longint unsigned ua, ub, up;
               ua = 64'(na); ub = 64'(mb); up = ua * ub;
               p = {16'h0, up};
            end else begin
               longint sa, sb, sp;
               sa = longint'(signed'(na)); sb = longint'(signed'(mb)); sp = sa * sb;
               p = {{16{sp[63]}}, sp};
            end
            if (s && (e % 2 == 1)) acc = acc - p;
            else acc = acc + p;
            acc = acc + 80'd128;
         end
      end
      return acc[71:8];
   endfunction

   // cycle model
   bit          m_busy = 0, m_done = 0, m_ill = 0;
   int          m_cnt = 0;
   logic [63:0] m_res = '0, m_pend = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_ill = 0; m_cnt = 0; m_res = '0;
      end else begin
         m_done = 0; m_ill = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 4) begin
               m_busy = 0; m_done = 1; m_res = m_pend;
            end
         end else if (start) begin
            if (unsigned_mode && (sub_odd || exchange)) begin
               m_done = 1; m_ill = 1; m_res = {acc_hi_in, acc_lo_in};
            end else begin
               m_busy = 1; m_cnt = 0;
               m_pend = ref_calc(vec_n, vec_m, {acc_hi_in, acc_lo_in}, pred_mask,
                                 unsigned_mode, sub_odd, exchange);
            end
         end
      end
   end

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check({busy, done, illegal} == {m_busy, m_done, m_ill}, cur_req, "busy/done/illegal",
               64'({busy, done, illegal}), 64'({m_busy, m_done, m_ill}));
         check({res_hi, res_lo} == m_res, cur_req, "result", {res_hi, res_lo}, m_res);
      end
   end

   task automatic drive(logic [127:0] n, logic [127:0] m, logic [63:0] a,
                        logic [15:0] msk, bit u, bit s, bit x);
      vec_n = n; vec_m = m; {acc_hi_in, acc_lo_in} = a; pred_mask = msk;
      unsigned_mode = u; sub_odd = s; exchange = x; start = 1'b1;
   endtask

   task automatic run_op(string req, logic [127:0] n, logic [127:0] m, logic [63:0] a,
                         logic [15:0] msk, bit u, bit s, bit x);
      @(negedge clk);
      cur_req = req;
      drive(n, m, a, msk, u, s, x);
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [127:0] lanes(int l3, int l2, int l1, int l0);
      return {32'(l3), 32'(l2), 32'(l1), 32'(l0)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs after reset, read while reset is still held
      check({busy, done, illegal} == 3'b000, "R1", "flags in reset", 64'({busy, done, illegal}), 64'd0);
      check({res_hi, res_lo} == 64'd0, "R1", "result in reset", {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;
      cur_req = "R1";
      repeat (2) @(negedge clk);

      // R2: no active lane returns the input sum; R8: only bit 4e counts
      run_op("R2", lanes(5, 6, 7, 8), lanes(9, 9, 9, 9), 64'h8123_4567_89AB_CDEF, 16'h0000, 0, 0, 0);
      run_op("R8", lanes(5, 6, 7, 8), lanes(9, 9, 9, 9), 64'h0000_0001_0000_0002, 16'hEEEE, 0, 0, 0);
      run_op("R8", lanes(5, 6, 7, 8), lanes(9, 9, 9, 9), 64'd77, 16'h0F01, 0, 0, 0);
      // R3: rounding builds up from lane increments
      run_op("R3", lanes(1, 1, 1, 1), lanes(1, 1, 1, 1), 64'd0, 16'hFFFF, 0, 0, 0);
      run_op("R3", lanes(0, 0, 0, 0), lanes(0, 0, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 16'h1111, 0, 0, 0);
      // R4: signed negative products
      run_op("R4", lanes(-3, 7, -100000, 32'h8000_0000), lanes(5, -9, 300000, 32'h8000_0000),
             64'h0000_0000_0000_1000, 16'hFFFF, 0, 0, 0);
      // R5: unsigned maximal products
      run_op("R5", {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 64'h1234_0000_0000_0000, 16'hFFFF, 1, 0, 0);
      run_op("R5", lanes(32'h8000_0001, 2, 3, 32'hF000_0000), lanes(3, 32'hC000_0000, 4, 16),
             64'd5, 16'h1011, 1, 0, 0);
      // R6: odd lanes subtract
      run_op("R6", lanes(10, 20, 30, 40), lanes(3, 5, 7, 11), 64'd1000, 16'hFFFF, 0, 1, 0);
      run_op("R6", lanes(-10, 20, 32'h7FFF_FFFF, 40), lanes(3, -5, 32'h7FFF_FFFF, 11), 64'd0, 16'h0110, 0, 1, 0);
      // R7: exchange pairing, alone and with subtract
      run_op("R7", lanes(1, 2, 3, 4), lanes(10, 100, 1000, 10000), 64'd0, 16'hFFFF, 0, 0, 1);
      run_op("R7", lanes(-1, 2, 3, -4), lanes(10, 100, -1000, 10000), 64'd9, 16'h1101, 0, 1, 1);
      // R9: rejected modes
      run_op("R9", lanes(1, 2, 3, 4), lanes(1, 2, 3, 4), 64'hDEAD_BEEF_0BAD_F00D, 16'hFFFF, 1, 1, 0);
      run_op("R9", lanes(1, 2, 3, 4), lanes(1, 2, 3, 4), 64'h0123_4567_0000_0042, 16'hFFFF, 1, 0, 1);

      // R10: start while busy is ignored
      @(negedge clk);
      cur_req = "R10";
      drive(lanes(4, 3, 2, 1), lanes(4, 3, 2, 1), 64'd11, 16'hFFFF, 0, 0, 0);
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      drive(lanes(99, 99, 99, 99), lanes(99, 99, 99, 99), 64'd0, 16'hFFFF, 0, 1, 1);
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);

      // R12: start in the done cycle, legal then rejected
      cur_req = "R12";
      drive(lanes(7, -7, 7, -7), lanes(2, 2, 2, 2), 64'd3, 16'hFFFF, 0, 0, 0);
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      drive(lanes(8, 8, 8, 8), lanes(-8, 8, -8, 8), 64'd100, 16'h1111, 0, 1, 0);
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      drive(lanes(0, 0, 0, 0), lanes(0, 0, 0, 0), 64'hCAFE_0000_0000_0001, 16'hFFFF, 1, 1, 1);
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);

      // R11: result holds while inputs wander without start
      cur_req = "R11";
      for (int i = 0; i < 8; i++) begin
         vec_n = {4{32'(i * 37)}}; acc_lo_in = 32'(i); pred_mask = 16'(i * 4099);
         @(negedge clk);
      end

      // R3: mixed random operations
      for (int i = 0; i < 40; i++) begin
         logic [127:0] rn, rm;
         logic [63:0]  ra;
         bit u, s, x;
         rn = {$urandom, $urandom, $urandom, $urandom};
         rm = {$urandom, $urandom, $urandom, $urandom};
         ra = {$urandom, $urandom};
         u = 1'($urandom); s = 1'($urandom); x = 1'($urandom);
         if (u && i % 3 != 0) begin s = 0; x = 0; end
         run_op("R3", rn, rm, ra, 16'($urandom), u, s, x);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule